// File: doc/BRIEF.md
# Dual-Bus Sample Demultiplexer with Strobe Gating

The block receives a full-rate stream of 12-bit two's complement samples over a valid/data interface, with one overrange bit per sample. It deals the accepted samples alternately to two parallel output buses, A and B. Each bus therefore changes at half the input rate. Both buses of a pair are loaded on the same clock edge, so a capture circuit downstream sees the A and B words together. Each bus has its own one-cycle data-ready strobe. A single overrange output shares bus B's timing and covers the whole pair.

A strobe-enable input lets a downstream buffer memory pick a clean starting point. While the enable is held low, both strobes stop. The buses keep updating. When the enable returns high, strobes restart on a bus-A strobe. A bus-B strobe is never issued for a pair whose A strobe was withheld.

An active-low asynchronous reset forces both buses and both strobes high and clears the overrange output. After release, strobes return only once a full pair has been collected.

Top module: `dual_bus_demux`

## Requirements
- R1: After reset, the first accepted sample (in_valid high at a clock edge) goes to bus A, and accepted samples then alternate A, B, A, B. Cycles with in_valid low do not advance the alternation.
- R2: bus_a and bus_b both update on the clock edge that accepts a B sample, and hold their values until the next pair completes.
- R3: Sample bits pass to the buses unchanged in 12-bit two's complement form, including 0x7FF (largest positive) and 0x800 (most negative).
- R4: When a pair completes and strobes are not halted, rdy_a is high for exactly the one cycle after that edge, and rdy_b is high for exactly the next cycle.
- R5: rdy_b is high only in the cycle immediately after a cycle in which rdy_a was high.
- R6: ovr_out updates with the buses and equals the OR of the A and B samples' overrange bits for that pair. It is 0 when neither sample was out of range.
- R7: A clock edge at which strobe_en is sampled low, after it was also sampled low at the previous edge, issues no strobe, whether for A or B. The buses and ovr_out still update.
- R8: A strobe_en low lasting a single clock edge has no effect on either strobe.
- R9: Once strobe_en is high again, strobes resume with rdy_a for the next completed pair. A pair whose rdy_a was issued but whose rdy_b edge was halted receives no late rdy_b.
- R10: While rst_n is low, bus_a and bus_b are all ones, rdy_a and rdy_b are 1, and ovr_out is 0. At the first edge after release both strobes drop to 0, and the alternation restarts at bus A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample on in_data is accepted at this edge |
| in_data | input | 12 | Two's complement input sample |
| in_ovr | input | 1 | Overrange bit of the input sample |
| strobe_en | input | 1 | Strobe enable; a low of two or more edges halts both strobes |
| bus_a | output | 12 | Output bus A, first sample of each pair |
| bus_b | output | 12 | Output bus B, second sample of each pair |
| rdy_a | output | 1 | Data-ready strobe for bus A |
| rdy_b | output | 1 | Data-ready strobe for bus B |
| ovr_out | output | 1 | Overrange flag for the pair, aligned with bus B |

## Verification
A table of sample pairs drives the main split function. The table holds the two's complement extremes, all-ones and alternating bit patterns, and each combination of overrange bits. This separates a swapped or shifted bus and a wrong overrange combination from correct behaviour. Pairs with an idle gap between A and B, and a back-to-back stream, show whether invalid cycles wrongly advance the alternation and whether both buses load together. Enable patterns test the gating: a held low, a one-edge pulse, and a low that starts exactly on a pair boundary. These separate the two-edge filter, the A-first restart and the suppression of an orphan B strobe. A reset taken half way through a pair shows that the alternation restarts on A.

// File: rtl/dual_bus_demux.sv
module dual_bus_demux #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         in_ovr,
  input  logic         strobe_en,
  output logic [W-1:0] bus_a,
  output logic [W-1:0] bus_b,
  output logic         rdy_a,
  output logic         rdy_b,
  output logic         ovr_out
);

  logic         phase_b;
  logic [W-1:0] hold_a;
  logic         hold_ovr;
  logic         en_low_d;
  logic         a_sent;

  wire take_a    = in_valid & ~phase_b;
  wire pair_done = in_valid & phase_b;
  wire halt      = ~strobe_en & en_low_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_b  <= 1'b0;
      hold_a   <= '0;
      hold_ovr <= 1'b0;
      en_low_d <= 1'b0;
      a_sent   <= 1'b0;
    end else begin
      if (in_valid) phase_b <= ~phase_b;
      if (take_a) begin
        hold_a   <= in_data;
        hold_ovr <= in_ovr;
      end
      en_low_d <= ~strobe_en;
      a_sent   <= pair_done & ~halt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_a   <= '1;
      bus_b   <= '1;
      rdy_a   <= 1'b1;
      rdy_b   <= 1'b1;
      ovr_out <= 1'b0;
    end else begin
      if (pair_done) begin
        bus_a   <= hold_a;
        bus_b   <= in_data;
        ovr_out <= hold_ovr | in_ovr;
      end
      rdy_a <= pair_done & ~halt;
      rdy_b <= a_sent & ~halt;
    end
  end

  a_r5_b_after_a: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && rdy_b) |-> $past(rdy_a));

  a_r7_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !strobe_en && $past(!strobe_en)) |=> (!rdy_a && !rdy_b));

  a_r2_pair_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && rdy_b) |-> ($stable(bus_a) && $stable(bus_b) && $stable(ovr_out)));

  a_r4_a_from_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && rdy_a) |-> $past(in_valid));

endmodule

// File: tb/dual_bus_demux_bench.sv
module dual_bus_demux_bench;
  localparam int PERIOD = 10;
  localparam int W = 12;
  localparam int NV = 7;
  // {a_data, a_ovr, b_data, b_ovr, expected ovr_out}
  localparam bit [2*W+2:0] VEC [NV] = '{
    {12'h000, 1'b0, 12'h001, 1'b0, 1'b0},
    {12'h7FF, 1'b0, 12'h800, 1'b0, 1'b0},
    {12'h800, 1'b0, 12'h7FF, 1'b1, 1'b1},
    {12'hFFF, 1'b1, 12'h123, 1'b0, 1'b1},
    {12'h5A5, 1'b1, 12'hA5A, 1'b1, 1'b1},
    {12'hABC, 1'b0, 12'h321, 1'b0, 1'b0},
    {12'h001, 1'b0, 12'hFFE, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n, in_valid, in_ovr, strobe_en;
  logic [W-1:0] in_data, bus_a, bus_b;
  logic rdy_a, rdy_b, ovr_out;
  int checks = 0;
  int errors = 0;

  dual_bus_demux #(.W(W)) u_dual_bus_demux (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ovr(in_ovr), .strobe_en(strobe_en), .bus_a(bus_a), .bus_b(bus_b),
    .rdy_a(rdy_a), .rdy_b(rdy_b), .ovr_out(ovr_out)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [W-1:0] d, logic o);
    in_valid = v; in_data = d; in_ovr = o;
  endtask

  task automatic run_pair(logic [W-1:0] a, logic ao, logic [W-1:0] b, logic bo, logic eo);
    @(negedge clk) drive(1'b1, a, ao);
    @(negedge clk) drive(1'b1, b, bo);
    @(negedge clk) drive(1'b0, '0, 1'b0);
    check("R3 bus_a", bus_a, a);
    check("R3 bus_b", bus_b, b);
    check("R6 ovr_out", ovr_out, eo);
    check("R4 rdy_a first", {rdy_a, rdy_b}, 2'b10);
    @(negedge clk);
    check("R4 rdy_b second", {rdy_a, rdy_b}, 2'b01);
    check("R2 bus_a held", bus_a, a);
    check("R2 bus_b held", bus_b, b);
    @(negedge clk);
    check("R4 strobes end", {rdy_a, rdy_b}, 2'b00);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strobe_en = 1'b1;
    drive(1'b0, '0, 1'b0);
    repeat (3) @(negedge clk);
    check("R10 reset buses", {bus_a, bus_b}, {2*W{1'b1}});
    check("R10 reset strobes/ovr", {rdy_a, rdy_b, ovr_out}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 strobes drop after release", {rdy_a, rdy_b}, 2'b00);

    for (int i = 0; i < NV; i++) begin
      run_pair(VEC[i][2*W+2:W+3], VEC[i][W+2], VEC[i][W+1:2], VEC[i][1], VEC[i][0]);
    end

    // R1: idle cycle between A and B does not advance alternation
    @(negedge clk) drive(1'b1, 12'h111, 1'b0);
    @(negedge clk) drive(1'b0, 12'h999, 1'b1);
    @(negedge clk) drive(1'b1, 12'h222, 1'b0);
    @(negedge clk) drive(1'b0, '0, 1'b0);
    check("R1 gap bus_a", bus_a, 12'h111);
    check("R1 gap bus_b", bus_b, 12'h222);
    check("R1 gap ovr", ovr_out, 1'b0);
    @(negedge clk);

    // R2: back-to-back stream
    @(negedge clk) drive(1'b1, 12'h0A1, 1'b0);
    @(negedge clk) drive(1'b1, 12'h0B1, 1'b0);
    @(negedge clk);
    check("R2 stream pair1", {bus_a, bus_b, rdy_a}, {12'h0A1, 12'h0B1, 1'b1});
    drive(1'b1, 12'h0A2, 1'b1);
    @(negedge clk);
    check("R2 stream hold", {bus_a, bus_b, rdy_b}, {12'h0A1, 12'h0B1, 1'b1});
    drive(1'b1, 12'h0B2, 1'b0);
    @(negedge clk);
    check("R2 stream pair2", {bus_a, bus_b, ovr_out, rdy_a}, {12'h0A2, 12'h0B2, 1'b1, 1'b1});
    drive(1'b0, '0, 1'b0);
    @(negedge clk);
    @(negedge clk);

    // R7: held-low enable halts strobes, buses still update
    strobe_en = 1'b0;
    @(negedge clk) drive(1'b1, 12'h3C3, 1'b0);
    @(negedge clk) drive(1'b1, 12'hC3C, 1'b1);
    @(negedge clk) drive(1'b0, '0, 1'b0);
    check("R7 no rdy_a", rdy_a, 1'b0);
    check("R7 buses update", {bus_a, bus_b, ovr_out}, {12'h3C3, 12'hC3C, 1'b1});
    @(negedge clk);
    check("R7 no rdy_b", rdy_b, 1'b0);
    strobe_en = 1'b1;
    // R9: resume with A
    run_pair(12'h456, 1'b0, 12'h789, 1'b0, 1'b0);

    // R9 / R5: halt starting on the pair edge cuts B, no late B
    @(negedge clk) drive(1'b1, 12'h6E6, 1'b0);
    @(negedge clk) begin drive(1'b1, 12'h161, 1'b0); strobe_en = 1'b0; end
    @(negedge clk) drive(1'b0, '0, 1'b0);
    check("R9 rdy_a before halt", {rdy_a, rdy_b}, 2'b10);
    @(negedge clk);
    check("R9 orphan rdy_b cut", {rdy_a, rdy_b}, 2'b00);
    strobe_en = 1'b1;
    @(negedge clk);
    check("R5 no late rdy_b", {rdy_a, rdy_b}, 2'b00);
    run_pair(12'h246, 1'b1, 12'h135, 1'b0, 1'b1);

    // R8: single-edge low pulse ignored
    @(negedge clk) drive(1'b1, 12'h0F0, 1'b0);
    @(negedge clk) begin drive(1'b1, 12'hF0F, 1'b0); strobe_en = 1'b0; end
    @(negedge clk) begin drive(1'b0, '0, 1'b0); strobe_en = 1'b1; end
    check("R8 rdy_a kept", {rdy_a, rdy_b}, 2'b10);
    @(negedge clk);
    check("R8 rdy_b kept", {rdy_a, rdy_b}, 2'b01);
    @(negedge clk);

    // R10: reset mid-pair restarts alternation on A
    @(negedge clk) drive(1'b1, 12'hDDD, 1'b0);
    @(negedge clk) begin drive(1'b0, '0, 1'b0); rst_n = 1'b0; end
    #1;
    check("R10 mid reset outputs", {bus_a, bus_b, rdy_a, rdy_b, ovr_out}, {{2*W{1'b1}}, 3'b110});
    @(negedge clk) rst_n = 1'b1;
    run_pair(12'h1A1, 1'b0, 12'h2B2, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule